// File: doc/BRIEF.md
# Dissemination Barrier Synchronization Unit

This block holds a group of agents at a common synchronization point. Each agent gives a one-cycle arrive pulse when it reaches the barrier. Each agent then gets a one-cycle release pulse, and that pulse comes only after every agent in the group has arrived. The number of agents is a parameter and does not need to be a power of two.

Each agent has its own small sequencer. The sequencer works through a fixed number of rounds. In each round it posts a flag to one peer, then watches its own flag for that round. Nothing is ever read, modified and written in one step: every flag is a plain register, written by exactly one agent and read by exactly one agent.

Two copies of the flag storage are used in turn. A per-agent sense bit tells the current barrier apart from older ones. Because of this, back-to-back barriers reuse the same registers without clearing them. Agents may move through the rounds at different speeds, and one agent may finish and arrive at the next barrier while slower agents are still leaving the last one.

Top module: `dbar_unit`

## Requirements
- R1: While reset is high and after it falls, no release pulse is given until an arrive has been accepted. Reset clears every flag to 0, and every sense bit and bank-select bit to 0.
- R2: An arrive pulse is accepted only when its agent is idle. An agent is idle from reset, and again from the cycle its release pulse is high. An arrive pulse on a busy agent is ignored and does not count as an arrival for any barrier.
- R3: No agent gets a release for barrier number g before every agent has had its g-th arrive accepted.
- R4: Each accepted arrive leads to exactly one release pulse on that agent. The pulse is high for exactly one cycle.
- R5: The number of rounds is ROUNDS = ceil(log2 NUM_AGENTS). In round r, agent i writes the round-r flag of agent (i + 2^r) mod NUM_AGENTS. Each round takes two cycles: one to post, one or more to check. If all agents arrive in the same cycle, every release is high 2*ROUNDS cycles after the edge that accepts the arrives.
- R6: If every other agent is already waiting, the last agent to arrive gets its release 2*ROUNDS cycles after the edge that accepts its arrive.
- R7: Flag storage has two banks, chosen by a per-agent bank bit. The bank bit toggles at every release. The sense bit inverts only when the bank bit was 1 before the toggle. The value posted is the inverse of the writer's sense, so every flag write changes the stored value. Three or more back-to-back barriers complete correctly.
- R8: An agent stays in a round while its own flag for that round equals its sense. It advances by at most one round per clock. Agents advance independently of each other.
- R9: The barrier works for a group size that is not a power of two. The default is 5 agents, which gives 3 rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arrive_i | input | NUM_AGENTS | One-cycle arrive pulse per agent |
| release_o | output | NUM_AGENTS | One-cycle release pulse per agent |

## Verification
The hardest case to reach is a fast agent that completes one barrier and arrives at the next one at once. At that moment slower agents are still in late rounds of the barrier before, and the two barriers use different flag banks and sense values. The stimulus runs several barriers with random per-agent arrival delays, including zero delay, so that arrive and release overlap in the same cycle. Directed phases cover the all-at-once latency, a late final arriver, and a second arrive pulse given while the agent is busy.

// File: rtl/dbar_pkg.sv
package dbar_pkg;

    // Per-agent sequencer state
    typedef enum logic [1:0] {
        AG_IDLE = 2'd0,
        AG_POST = 2'd1,
        AG_POLL = 2'd2
    } agent_st_e;

    // Rounds needed for n agents
    function automatic int unsigned round_count(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Width of a round index
    function automatic int unsigned round_width(input int unsigned rounds);
        return (rounds < 2) ? 1 : $clog2(rounds);
    endfunction

    // Agent that writes agent j's flag in round r
    function automatic int unsigned writer_of(input int unsigned j,
                                              input int unsigned r,
                                              input int unsigned n);
        return (j + n - ((1 << r) % n)) % n;
    endfunction

endpackage

// File: rtl/dbar_flag_store.sv
module dbar_flag_store
    import dbar_pkg::*;
#(
    parameter int unsigned NUM_AGENTS = 5,
    parameter int unsigned ROUNDS     = 3,
    parameter int unsigned RW         = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_AGENTS-1:0]         wr_en,
    input  logic [NUM_AGENTS-1:0]         wr_bank,
    input  logic [NUM_AGENTS-1:0][RW-1:0] wr_round,
    input  logic [NUM_AGENTS-1:0]         wr_val,
    input  logic [NUM_AGENTS-1:0]         rd_bank,
    input  logic [NUM_AGENTS-1:0][RW-1:0] rd_round,
    output logic [NUM_AGENTS-1:0]         rd_flag
);

    logic [1:0][ROUNDS-1:0] flag_v [NUM_AGENTS];

    for (genvar j = 0; j < NUM_AGENTS; j++) begin : g_owner
        for (genvar b = 0; b < 2; b++) begin : g_bank
            for (genvar r = 0; r < ROUNDS; r++) begin : g_round
                localparam int unsigned WR = writer_of(j, r, NUM_AGENTS);
                logic hit;
                logic cell_q;

                assign hit = wr_en[WR] && (wr_bank[WR] == 1'(b))
                             && (wr_round[WR] == RW'(r));

                always_ff @(posedge clk) begin
                    if (rst) begin
                        cell_q <= 1'b0;
                    end else if (hit) begin
                        cell_q <= wr_val[WR];
                    end
                end

                assign flag_v[j][b][r] = cell_q;

                // R7
                flag_flip_chk: assert property (@(posedge clk) disable iff (rst)
                    hit |-> (cell_q != wr_val[WR]));
            end
        end
    end

    always_comb begin
        for (int j = 0; j < NUM_AGENTS; j++) begin
            rd_flag[j] = flag_v[j][rd_bank[j]][rd_round[j]];
        end
    end

endmodule

// File: rtl/dbar_agent.sv
module dbar_agent
    import dbar_pkg::*;
#(
    parameter int unsigned ROUNDS = 3,
    parameter int unsigned RW     = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arrive,
    input  logic          flag_in,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [RW-1:0] wr_round,
    output logic          wr_val,
    output logic          rd_bank,
    output logic [RW-1:0] rd_round,
    output logic          release_o
);

    localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

    agent_st_e     st_q;
    logic [RW-1:0] round_q;
    logic          sense_q;
    logic          bank_q;
    logic          rel_q;

    assign wr_en     = (st_q == AG_POST);
    assign wr_bank   = bank_q;
    assign wr_round  = round_q;
    assign wr_val    = ~sense_q;
    assign rd_bank   = bank_q;
    assign rd_round  = round_q;
    assign release_o = rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= AG_IDLE;
            round_q <= '0;
            sense_q <= 1'b0;
            bank_q  <= 1'b0;
            rel_q   <= 1'b0;
        end else begin
            rel_q <= 1'b0;
            unique case (st_q)
                AG_IDLE: begin
                    if (arrive) begin
                        st_q    <= AG_POST;
                        round_q <= '0;
                    end
                end
                AG_POST: begin
                    st_q <= AG_POLL;
                end
                AG_POLL: begin
                    if (flag_in != sense_q) begin
                        if (round_q == LAST) begin
                            st_q   <= AG_IDLE;
                            rel_q  <= 1'b1;
                            bank_q <= ~bank_q;
                            if (bank_q) begin
                                sense_q <= ~sense_q;
                            end
                        end else begin
                            st_q    <= AG_POST;
                            round_q <= round_q + 1'b1;
                        end
                    end
                end
                default: st_q <= AG_IDLE;
            endcase
        end
    end

    // R4
    rel_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rel_q |=> !rel_q);

    // R8
    round_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == AG_POLL && flag_in == sense_q) |=>
        (st_q == AG_POLL && $stable(round_q)));

    // R8
    round_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == AG_POLL) |=>
        ((st_q == AG_POLL && round_q == $past(round_q)) ||
         (st_q == AG_POST && round_q == $past(round_q) + 1'b1) ||
         (st_q == AG_IDLE && rel_q)));

    // R2
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != AG_IDLE && arrive) |=> !(st_q == AG_POST && round_q == '0));

endmodule

// File: rtl/dbar_unit.sv
module dbar_unit
    import dbar_pkg::*;
#(
    parameter int unsigned NUM_AGENTS = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_AGENTS-1:0] arrive_i,
    output logic [NUM_AGENTS-1:0] release_o
);

    localparam int unsigned ROUNDS = round_count(NUM_AGENTS);
    localparam int unsigned RW     = round_width(ROUNDS);

    logic [NUM_AGENTS-1:0]         wr_en;
    logic [NUM_AGENTS-1:0]         wr_bank;
    logic [NUM_AGENTS-1:0][RW-1:0] wr_round;
    logic [NUM_AGENTS-1:0]         wr_val;
    logic [NUM_AGENTS-1:0]         rd_bank;
    logic [NUM_AGENTS-1:0][RW-1:0] rd_round;
    logic [NUM_AGENTS-1:0]         rd_flag;

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
        dbar_agent #(
            .ROUNDS (ROUNDS),
            .RW     (RW)
        ) u_agent (
            .clk       (clk),
            .rst       (rst),
            .arrive    (arrive_i[i]),
            .flag_in   (rd_flag[i]),
            .wr_en     (wr_en[i]),
            .wr_bank   (wr_bank[i]),
            .wr_round  (wr_round[i]),
            .wr_val    (wr_val[i]),
            .rd_bank   (rd_bank[i]),
            .rd_round  (rd_round[i]),
            .release_o (release_o[i])
        );
    end

    dbar_flag_store #(
        .NUM_AGENTS (NUM_AGENTS),
        .ROUNDS     (ROUNDS),
        .RW         (RW)
    ) u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_round (wr_round),
        .wr_val   (wr_val),
        .rd_bank  (rd_bank),
        .rd_round (rd_round),
        .rd_flag  (rd_flag)
    );

endmodule

// File: tb/test_dbar_unit.sv
module test_dbar_unit;

    localparam int P  = 5;
    localparam int R  = $clog2(P);
    localparam int NB = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic [P-1:0] arrive;
    logic [P-1:0] rel;
    logic [P-1:0] dir_arr;
    logic         rnd_arr [P];
    logic         rnd_done [P];
    logic         go_rand;

    int acc [P];
    int relcnt [P];
    logic [P-1:0] prev_rel;
    int mon_chk = 0, mon_err = 0;
    int main_chk = 0, main_err = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < P; i++) arrive[i] = dir_arr[i] | rnd_arr[i];
    end

    dbar_unit #(.NUM_AGENTS(P)) i_dbar_unit (
        .clk       (clk),
        .rst       (rst),
        .arrive_i  (arrive),
        .release_o (rel)
    );

    // Model of accepted arrivals (R2): accepted only when agent is idle
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < P; i++) acc[i] = 0;
        end else begin
            for (int i = 0; i < P; i++)
                if (arrive[i] && acc[i] == relcnt[i]) acc[i] = acc[i] + 1;
        end
    end

    // Release monitor: R3 safety, R4 pulse and pairing
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < P; i++) relcnt[i] = 0;
            prev_rel = '0;
        end else begin
            for (int i = 0; i < P; i++) begin
                if (rel[i]) begin
                    mon_chk++;
                    if (prev_rel[i]) begin
                        mon_err++;
                        $display("FAIL R4 agent %0d release wider than one cycle: act=1 exp=0", i);
                    end
                    mon_chk++;
                    if (acc[i] <= relcnt[i]) begin
                        mon_err++;
                        $display("FAIL R4 agent %0d release without accepted arrive: act=%0d exp>%0d", i, acc[i], relcnt[i]);
                    end
                    for (int j = 0; j < P; j++) begin
                        mon_chk++;
                        if (acc[j] <= relcnt[i]) begin
                            mon_err++;
                            $display("FAIL R3 agent %0d released in barrier %0d before agent %0d arrived: act=%0d exp>=%0d",
                                     i, relcnt[i], j, acc[j], relcnt[i] + 1);
                        end
                    end
                    relcnt[i] = relcnt[i] + 1;
                end
            end
            prev_rel = rel;
        end
    end

    // Random per-agent arrival processes (R7, R8, R9)
    for (genvar g = 0; g < P; g++) begin : g_rnd
        initial begin
            rnd_arr[g]  = 1'b0;
            rnd_done[g] = 1'b0;
            wait (go_rand);
            for (int b = 0; b < NB; b++) begin
                repeat ($urandom_range(0, 12)) @(negedge clk);
                rnd_arr[g] = 1'b1;
                @(negedge clk);
                rnd_arr[g] = 1'b0;
                while (!rel[g]) @(negedge clk);
            end
            rnd_done[g] = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [P-1:0] act,
                       input logic [P-1:0] exp);
        main_chk++;
        if (!ok) begin
            main_err++;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    function automatic logic [P-1:0] all_ones();
        return '1;
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired: act=hung exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 main_chk + mon_chk + 1, main_err + mon_err + 1);
        $finish;
    end

    initial begin
        bit all_done;
        void'($urandom(32'd1234));
        rst     = 1'b1;
        dir_arr = '0;
        go_rand = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(rel == '0, "R1 during reset", rel, '0);
        end
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(rel == '0, "R1 after reset", rel, '0);
        end

        // R5, R9: all agents arrive together
        dir_arr = all_ones();
        @(negedge clk);
        dir_arr = '0;
        for (int k = 0; k <= 2 * R; k++) begin
            if (k > 0) @(negedge clk);
            chk(rel == ((k == 2 * R) ? all_ones() : '0), "R5 simultaneous latency", rel,
                (k == 2 * R) ? all_ones() : '0);
        end
        @(negedge clk);
        chk(rel == '0, "R4 one-cycle pulse", rel, '0);

        // R2: extra arrive on a busy agent is ignored
        dir_arr = all_ones();
        @(negedge clk);
        dir_arr = '0;
        @(negedge clk);
        dir_arr = 5'b00001;
        @(negedge clk);
        dir_arr = '0;
        while (!rel[0]) @(negedge clk);
        chk(rel == all_ones(), "R7 second barrier all released", rel, all_ones());
        @(negedge clk);
        dir_arr = 5'b11110;
        @(negedge clk);
        dir_arr = '0;
        repeat (30) begin
            @(negedge clk);
            chk(rel == '0, "R2 busy arrive not counted", rel, '0);
        end

        // R6: last arriver
        dir_arr = 5'b00001;
        @(negedge clk);
        dir_arr = '0;
        for (int k = 0; k <= 2 * R; k++) begin
            if (k > 0) @(negedge clk);
            chk(rel[0] == (k == 2 * R), "R6 last arriver latency", {4'b0, rel[0]},
                {4'b0, 1'(k == 2 * R)});
        end
        repeat (4 * R) @(negedge clk);
        for (int i = 0; i < P; i++)
            chk(acc[i] == relcnt[i] && relcnt[i] == 3, "R4 releases match arrivals",
                P'(relcnt[i]), P'(3));

        // R7, R8, R9: randomised back-to-back barriers
        go_rand = 1'b1;
        do begin
            @(negedge clk);
            all_done = 1'b1;
            for (int i = 0; i < P; i++) if (!rnd_done[i]) all_done = 1'b0;
        end while (!all_done);
        repeat (4 * R) @(negedge clk);
        for (int i = 0; i < P; i++)
            chk(acc[i] == relcnt[i] && relcnt[i] == 3 + NB, "R7 back-to-back barriers complete",
                P'(relcnt[i]), P'(3 + NB));
        chk(rel == '0, "R8 quiet after random phase", rel, '0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 main_chk + mon_chk, main_err + mon_err);
        $finish;
    end

endmodule